// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer, with the timer's up-counter included. The counter advances on each cycle in which the tick input is high. It runs from zero up to a programmable reload limit and then returns to zero. Whenever the counter takes a value equal to the channel's compare value, a reference level is driven high, driven low, toggled or left alone, as the two-bit mode input selects. The same event sets a sticky channel flag, which the interrupt and DMA request outputs pass on under their own enables.

The pin level is derived from the reference level through a polarity bit and an output enable. The compare value can be written directly. It can also be written through a holding buffer that is copied into the live compare value only when the counter wraps, so that a change of pulse position never lands in the middle of a period. The reload value sets the period and the compare value sets where the edge falls inside it.

Top module: `ocmp_channel`

## Requirements
- R1: On a cycle with `tick_i` high, `count_o` advances by one, or goes to 0 if it is at or above `reload_i`. On a cycle with `tick_i` low it holds.
- R2: A match is detected in a cycle when the counter changed value on the previous edge and equals the live compare value. A match sets `flag_o` on the following edge. With a compare value of 0, the match occurs in the cycle after a wrap.
- R3: Mode 2'b01: a match drives the reference level to 1.
- R4: Mode 2'b10: a match drives the reference level to 0.
- R5: Mode 2'b11: a match inverts the reference level.
- R6: Mode 2'b00: a match leaves the reference level unchanged but still sets `flag_o`.
- R7: `irq_o` is `flag_o` AND `irq_en_i`. `dma_o` is `flag_o` AND `dma_en_i`.
- R8: `flag_clr_i` clears `flag_o` on the next edge. If a match occurs in the same cycle, the flag is set instead.
- R9: With `out_en_i` high, `pin_o` equals the reference level XOR `pol_i`. With `pol_i` at 0 the active level is high.
- R10: With `out_en_i` low, `pin_o` equals `pol_i`, which is the inactive level.
- R11: With `shadow_en_i` low, a write (`cmp_wr_i` high) makes `cmp_data_i` the live compare value from the next cycle.
- R12: With `shadow_en_i` high, a write goes to a buffer. The buffer becomes the live compare value on the next wrap edge, so the first value compared after the wrap already uses it.
- R13: After reset, the counter is 0, the reference level is 0, the flag is 0 and the live compare value is 0. The counter value that stands after reset is not a match until the counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance enable |
| reload_i | input | CNT_W | Highest counter value before the wrap |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | CNT_W | Compare value write data |
| shadow_en_i | input | 1 | Route compare writes through the wrap-time buffer |
| mode_i | input | 2 | Action on match: 00 none, 01 set, 10 clear, 11 toggle |
| pol_i | input | 1 | 0 = active high, 1 = active low |
| out_en_i | input | 1 | Drive the compare level onto the pin |
| irq_en_i | input | 1 | Interrupt request enable |
| dma_en_i | input | 1 | DMA request enable |
| flag_clr_i | input | 1 | Clear the channel flag |
| count_o | output | CNT_W | Current counter value |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request |
| pin_o | output | 1 | Channel output pin level |

## Verification
Every cycle is compared against a reference model written from the requirements. A continuous tick with a mid-period compare value tells the four match actions apart: set and clear settle after the first match, while toggle alternates every period. Ticks with gaps show that the counter holds and that a held value is not matched twice. A compare value of zero, a reload value that is lowered, and a buffered write placed in the middle of a period separate direct updates from wrap-timed ones. Sweeps of the polarity bit, output enable and request enables, together with a clear that lands on a match, separate the output gating from the flag priority.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [1:0] {
    OC_HOLD   = 2'b00,
    OC_SET    = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_TOGGLE = 2'b11
  } oc_mode_e;
endpackage

// File: rtl/ocmp_rst_sync.sv
module ocmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fresh_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fresh_q, fresh_d;
  logic             at_top;

  always_comb begin
    at_top  = (cnt_q >= reload_i);
    wrap_o  = tick_i && at_top;
    cnt_d   = cnt_q;
    if (tick_i) begin
      if (at_top) cnt_d = '0;
      else        cnt_d = CNT_W'(cnt_q + 1'b1);
    end
    fresh_d = tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign fresh_o = fresh_q;

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q >= reload_i) |=> (cnt_q == '0));
  p_hold_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && !fresh_q));
endmodule

// File: rtl/ocmp_cmp_store.sv
module ocmp_cmp_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             shadow_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] live_o
);
  logic [CNT_W-1:0] live_q, live_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             pend_q, pend_d;

  always_comb begin
    live_d = live_q;
    hold_d = hold_q;
    pend_d = pend_q;
    if (wrap_i && pend_q) begin
      live_d = hold_q;
      pend_d = 1'b0;
    end
    if (wr_i) begin
      if (shadow_i) begin
        hold_d = wdata_i;
        pend_d = 1'b1;
      end else begin
        live_d = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      live_q <= live_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign live_o = live_q;

  p_direct_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !shadow_i) |=> (live_q == $past(wdata_i)));
  p_buffer_waits_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && !shadow_i) && !wrap_i) |=> $stable(live_q));
endmodule

// File: rtl/ocmp_out_stage.sv
module ocmp_out_stage
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fresh_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       mode_i,
  input  logic             flag_clr_i,
  output logic             ref_o,
  output logic             flag_o
);
  oc_mode_e mode;
  logic     hit;
  logic     ref_q, ref_d;
  logic     flag_q, flag_d;

  always_comb begin
    mode = oc_mode_e'(mode_i);
    hit  = fresh_i && (cnt_i == cmp_i);
    ref_d = ref_q;
    if (hit) begin
      case (mode)
        OC_SET:    ref_d = 1'b1;
        OC_CLEAR:  ref_d = 1'b0;
        OC_TOGGLE: ref_d = ~ref_q;
        default:   ref_d = ref_q;
      endcase
    end
    flag_d = flag_q;
    if (flag_clr_i) flag_d = 1'b0;
    if (hit)        flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      flag_q <= flag_d;
    end
  end

  assign ref_o  = ref_q;
  assign flag_o = flag_q;

  p_match_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh_i && cnt_i == cmp_i) |=> flag_q);
  p_set_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh_i && cnt_i == cmp_i && mode_i == 2'b01) |=> ref_q);
  p_clear_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh_i && cnt_i == cmp_i && mode_i == 2'b10) |=> !ref_q);
  p_toggle_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh_i && cnt_i == cmp_i && mode_i == 2'b11) |=> (ref_q != $past(ref_q)));
  p_hold_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fresh_i && cnt_i == cmp_i) || mode_i == 2'b00) |=> $stable(ref_q));
  p_clear_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(fresh_i && cnt_i == cmp_i)) |=> !flag_q);
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             shadow_en_i,
  input  logic [1:0]       mode_i,
  input  logic             pol_i,
  input  logic             out_en_i,
  input  logic             irq_en_i,
  input  logic             dma_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             dma_o,
  output logic             pin_o
);
  logic             rst_n_s;
  logic [CNT_W-1:0] cnt;
  logic             fresh;
  logic             wrap;
  logic [CNT_W-1:0] live_cmp;
  logic             ref_lvl;
  logic             flag;

  ocmp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  ocmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .tick_i   (tick_i),
    .reload_i (reload_i),
    .cnt_o    (cnt),
    .fresh_o  (fresh),
    .wrap_o   (wrap)
  );

  ocmp_cmp_store #(.CNT_W(CNT_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .wr_i     (cmp_wr_i),
    .wdata_i  (cmp_data_i),
    .shadow_i (shadow_en_i),
    .wrap_i   (wrap),
    .live_o   (live_cmp)
  );

  ocmp_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .cnt_i      (cnt),
    .fresh_i    (fresh),
    .cmp_i      (live_cmp),
    .mode_i     (mode_i),
    .flag_clr_i (flag_clr_i),
    .ref_o      (ref_lvl),
    .flag_o     (flag)
  );

  always_comb begin
    count_o = cnt;
    flag_o  = flag;
    irq_o   = flag && irq_en_i;
    dma_o   = flag && dma_en_i;
    pin_o   = out_en_i ? (ref_lvl ^ pol_i) : pol_i;
  end

  p_zero_match_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (fresh && cnt == '0 && live_cmp == '0) |=> flag_o);
  p_disabled_pin_r10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!out_en_i && !$past(ref_lvl)) |-> (pin_o == pol_i));
endmodule

// File: tb/sim_ocmp_channel.sv
module sim_ocmp_channel;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] cnt;
    logic         flag;
    logic         irq;
    logic         dma;
    logic         pin;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] c_reload = 16'd7;
  logic         c_shadow = 1'b0, c_pol = 1'b0, c_oe = 1'b0;
  logic         c_ien = 1'b0, c_den = 1'b0;
  logic [1:0]   c_mode = 2'b00;

  logic [W-1:0] count_o;
  logic         flag_o, irq_o, dma_o, pin_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  // reference model state
  logic [W-1:0] m_cnt = '0, m_act = '0, m_buf = '0;
  logic         m_fresh = 0, m_pend = 0, m_ref = 0, m_flag = 0;

  always #4 clk = ~clk;

  ocmp_channel #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reload_i(c_reload),
    .cmp_wr_i(wr), .cmp_data_i(wd), .shadow_en_i(c_shadow), .mode_i(c_mode),
    .pol_i(c_pol), .out_en_i(c_oe), .irq_en_i(c_ien), .dma_en_i(c_den),
    .flag_clr_i(clr), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o),
    .dma_o(dma_o), .pin_o(pin_o)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: called at a falling edge; drives one cycle and queues the result
  task automatic cyc(input logic t, input logic w, input logic [W-1:0] d,
                     input logic c, input string tag);
    logic wrap, hit;
    exp_t e;
    tick = t; wr = w; wd = d; clr = c;
    wrap = t && (m_cnt >= c_reload);
    hit  = m_fresh && (m_cnt == m_act);
    if (wrap && m_pend) begin m_act = m_buf; m_pend = 0; end
    if (w) begin
      if (c_shadow) begin m_buf = d; m_pend = 1; end
      else m_act = d;
    end
    if (hit) begin
      if (c_mode == 2'b01) m_ref = 1;
      else if (c_mode == 2'b10) m_ref = 0;
      else if (c_mode == 2'b11) m_ref = !m_ref;
    end
    m_flag = hit ? 1'b1 : (c ? 1'b0 : m_flag);
    if (t) m_cnt = wrap ? '0 : m_cnt + 1'b1;
    m_fresh = t;
    e.cnt  = m_cnt;
    e.flag = m_flag;
    e.irq  = m_flag & c_ien;
    e.dma  = m_flag & c_den;
    e.pin  = c_oe ? (m_ref ^ c_pol) : c_pol;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, tag);
  endtask

  // monitor: compares each queued item shortly after the edge it belongs to
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (count_o !== e.cnt || flag_o !== e.flag || irq_o !== e.irq ||
          dma_o !== e.dma || pin_o !== e.pin) begin
        errors++;
        $display("FAIL %s: cnt/flag/irq/dma/pin actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
                 t, count_o, flag_o, irq_o, dma_o, pin_o,
                 e.cnt, e.flag, e.irq, e.dma, e.pin);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    checks++;
    if (count_o !== '0 || flag_o !== 0 || irq_o !== 0 || dma_o !== 0 || pin_o !== 0) begin
      errors++;
      $display("FAIL R13 reset: cnt/flag/irq/dma/pin actual %0d/%b/%b/%b/%b expected 0/0/0/0/0",
               count_o, flag_o, irq_o, dma_o, pin_o);
    end
    c_oe = 1; c_mode = 2'b01;
    cyc(0, 0, '0, 0, "R13 no match on reset value");
    checks++;
    if (pin_o !== 0) begin
      errors++;
      $display("FAIL R13 pin: actual %b expected 0", pin_o);
    end

    cyc(0, 1, 16'd3, 0, "R11 direct write");
    run(20, "R3 set on match / R1 wrap");
    c_mode = 2'b10;  run(10, "R4 clear on match");
    c_mode = 2'b11;  run(20, "R5 toggle on match");
    c_mode = 2'b00;
    cyc(0, 0, '0, 1, "R8 clear flag");
    run(10, "R6 frozen level, flag set");
    for (int i = 0; i < 16; i++) cyc(i[0], 0, '0, 0, "R1 hold on idle tick");

    c_mode = 2'b11; c_ien = 1;
    cyc(0, 0, '0, 1, "R8 clear flag");
    run(8, "R7 interrupt request");
    c_ien = 0; c_den = 1;
    cyc(0, 0, '0, 1, "R8 clear flag");
    run(8, "R7 DMA request");
    for (int i = 0; i < 10; i++) cyc(1, 0, '0, 1, "R8 match beats clear");

    c_pol = 1; run(10, "R9 active low output");
    c_oe = 0;  run(4, "R10 disabled, pol 1");
    c_pol = 0; run(4, "R10 disabled, pol 0");
    c_oe = 1;

    cyc(1, 1, 16'd0, 0, "R11 write zero");
    run(20, "R2 zero compare after wrap");

    c_shadow = 1;
    run(3, "R12 shadow setup");
    cyc(1, 1, 16'd5, 0, "R12 buffered write");
    run(20, "R12 takes effect at wrap");

    c_reload = 16'd3;
    run(12, "R1 short period");
    c_shadow = 0;
    cyc(1, 1, 16'd2, 0, "R11 write in short period");
    run(10, "R5 toggle short period");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule